// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the two cross-port interrupts for a shared memory that two agents reach through independent ports. Two addresses at the top of the address space act as mailboxes. When the left agent writes the highest address, the right agent is interrupted. The right agent acknowledges by reading that same address. In the other direction, a write by the right agent to the address one below the top interrupts the left agent, and the left agent acknowledges by reading it. The memory array, the data path and access arbitration are outside this block. It only watches each port's control strobes and address and keeps one flag per side.

All port inputs are sampled on the rising edge of one clock. Each port has an active-low enable, an active-low write select (high means read), an active-low output enable and an address. A set is triggered once per write access, in the cycle where enable and write select first become jointly asserted, whichever of the two comes last. A clear happens in every cycle in which the owning port performs an enabled read of its mailbox with the output enable asserted. If a set and a clear of one flag land in the same cycle, the set wins. Both interrupt outputs are active low, driven by a register, and return high on reset.

Top module: `mbx_irq_intr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both l_irq_n and r_irq_n are 1.
- R2: A left write access (l_en_n=0, l_wr_n=0) that starts in a cycle where l_addr is 0xFFF drives r_irq_n to 0 after the clock edge that samples it.
- R3: A right read (r_en_n=0, r_wr_n=1, r_oe_n=0) with r_addr 0xFFF drives r_irq_n to 1 after the sampling edge, unless a set of the same flag happens in that cycle.
- R4: A right write access (r_en_n=0, r_wr_n=0) that starts in a cycle where r_addr is 0xFFE drives l_irq_n to 0 after the sampling edge.
- R5: A left read (l_en_n=0, l_wr_n=1, l_oe_n=0) with l_addr 0xFFE drives l_irq_n to 1 after the sampling edge, unless a set of the same flag happens in that cycle.
- R6: A set is triggered only in the first cycle in which a port's enable and write select are both low, whichever went low last. Holding the write access, or moving its address onto the mailbox while it is held, triggers no further set.
- R7: A port's write to its own clearing address, a port's read of the address it sets, and any access to other addresses leave both interrupt outputs unchanged.
- R8: A read with the output enable high (deasserted), or with the port's enable high, does not clear an interrupt.
- R9: When a set and a clear of the same flag occur in the same cycle, the flag ends up active (output 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| l_en_n | input | 1 | Left port enable, active low |
| l_wr_n | input | 1 | Left port write select, 0 = write, 1 = read |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | 12 | Left port address |
| r_en_n | input | 1 | Right port enable, active low |
| r_wr_n | input | 1 | Right port write select, 0 = write, 1 = read |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | 12 | Right port address |
| l_irq_n | output | 1 | Interrupt toward the left agent, active low |
| r_irq_n | output | 1 | Interrupt toward the right agent, active low |

## Verification
Every result is due exactly one clock edge after the cycle that carries its stimulus, because the only path from a port to an interrupt pin is one flag register, and write-start detection compares with the previous cycle's strobe without adding delay. The bench applies each cycle's inputs on the falling edge, lets one rising edge pass and reads the outputs at the next falling edge. Each expected value therefore belongs to the cycle just driven. Multi-cycle scenarios, such as a write access held across a clear or an enable arriving after the write select, are checked one cycle at a time, so that a set firing one cycle early or late shows up as a mismatch.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // decoded, active-high view of one port's control pins
  typedef struct packed {
    logic enable;
    logic write;
    logic out_en;
  } port_ctl_t;

  function automatic port_ctl_t decode_ctl(input logic en_n, input logic wr_n,
                                           input logic oe_n);
    port_ctl_t c;
    c.enable = ~en_n;
    c.write  = ~wr_n;
    c.out_en = ~oe_n;
    return c;
  endfunction

  // a write access is in progress
  function automatic logic is_write(input port_ctl_t c);
    return c.enable & c.write;
  endfunction

  // a read that actually puts data on the bus
  function automatic logic is_read(input port_ctl_t c);
    return c.enable & ~c.write & c.out_en;
  endfunction

  // next flag state: set has priority over clear
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    logic n;
    if (set)      n = 1'b1;
    else if (clr) n = 1'b0;
    else          n = cur;
    return n;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] SET_ADDR = '1,
  parameter logic [ADDR_W-1:0] CLR_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              set_remote,
  output logic              clr_own,
  output logic              wr_start
);

  port_ctl_t ctl;
  logic      wr_now;
  logic      wr_prev;
  logic      rd_now;

  always_comb begin
    ctl    = decode_ctl(en_n, wr_n, oe_n);
    wr_now = is_write(ctl);
    rd_now = is_read(ctl);
  end

  // previous strobe state; during reset it tracks the pins so that a
  // write already under way when reset lifts is not seen as a new one
  always_ff @(posedge clk) begin
    if (!rst_n) wr_prev <= wr_now;
    else        wr_prev <= wr_now;
  end

  assign wr_start   = wr_now & ~wr_prev;
  assign set_remote = wr_start & (addr == SET_ADDR);
  assign clr_own    = rd_now & (addr == CLR_ADDR);

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag
  import mbx_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) active <= 1'b0;
    else        active <= flag_next(active, set, clr);
  end

  assign irq_n = ~active;

endmodule

// File: rtl/mbx_irq_intr.sv
module mbx_irq_intr
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en_n,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en_n,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);

  localparam int NSIDE = 2;
  localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

  logic [NSIDE-1:0]             en_n_v, wr_n_v, oe_n_v;
  logic [NSIDE-1:0][ADDR_W-1:0] addr_v;
  logic [NSIDE-1:0]             set_remote_v, clr_own_v, wr_start_v;
  logic [NSIDE-1:0]             irq_n_v;

  assign en_n_v[SIDE_LEFT]  = l_en_n;
  assign en_n_v[SIDE_RIGHT] = r_en_n;
  assign wr_n_v[SIDE_LEFT]  = l_wr_n;
  assign wr_n_v[SIDE_RIGHT] = r_wr_n;
  assign oe_n_v[SIDE_LEFT]  = l_oe_n;
  assign oe_n_v[SIDE_RIGHT] = r_oe_n;
  assign addr_v[SIDE_LEFT]  = l_addr;
  assign addr_v[SIDE_RIGHT] = r_addr;

  // side 0 (left) writes TOP to interrupt the right, reads NEXT to acknowledge;
  // side 1 (right) does the mirror image
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [ADDR_W-1:0] SET_A = (s == 0) ? TOP_ADDR  : NEXT_ADDR;
    localparam logic [ADDR_W-1:0] CLR_A = (s == 0) ? NEXT_ADDR : TOP_ADDR;

    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .SET_ADDR(SET_A),
      .CLR_ADDR(CLR_A)
    ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_n      (en_n_v[s]),
      .wr_n      (wr_n_v[s]),
      .oe_n      (oe_n_v[s]),
      .addr      (addr_v[s]),
      .set_remote(set_remote_v[s]),
      .clr_own   (clr_own_v[s]),
      .wr_start  (wr_start_v[s])
    );

    mbx_irq_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set_remote_v[NSIDE-1-s]),
      .clr  (clr_own_v[s]),
      .irq_n(irq_n_v[s])
    );
  end

  // named internal events for the checker
  logic l_set_evt, l_clr_evt, r_set_evt, r_clr_evt;
  logic l_wr_start, r_wr_start;

  assign l_set_evt  = set_remote_v[SIDE_RIGHT];
  assign l_clr_evt  = clr_own_v[SIDE_LEFT];
  assign r_set_evt  = set_remote_v[SIDE_LEFT];
  assign r_clr_evt  = clr_own_v[SIDE_RIGHT];
  assign l_wr_start = wr_start_v[SIDE_LEFT];
  assign r_wr_start = wr_start_v[SIDE_RIGHT];

  assign l_irq_n = irq_n_v[SIDE_LEFT];
  assign r_irq_n = irq_n_v[SIDE_RIGHT];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en_n,
  input logic              l_wr_n,
  input logic              l_oe_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_en_n,
  input logic              r_wr_n,
  input logic              r_oe_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_irq_n,
  input logic              r_irq_n,
  input logic              l_set_evt,
  input logic              l_clr_evt,
  input logic              r_set_evt,
  input logic              r_clr_evt
);

  localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

  assert_r_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    r_set_evt |=> !r_irq_n);

  assert_r_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_clr_evt && !r_set_evt) |=> r_irq_n);

  assert_l_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l_set_evt |=> !l_irq_n);

  assert_l_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_clr_evt && !l_set_evt) |=> l_irq_n);

  assert_r_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    r_set_evt |-> (!l_en_n && !l_wr_n && l_addr == HI &&
                   !$past(!l_en_n && !l_wr_n)));

  assert_l_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    l_set_evt |-> (!r_en_n && !r_wr_n && r_addr == LO &&
                   !$past(!r_en_n && !r_wr_n)));

  assert_r_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_set_evt && !r_clr_evt) |=> $stable(r_irq_n));

  assert_l_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_set_evt && !l_clr_evt) |=> $stable(l_irq_n));

  assert_r_rdqual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    r_clr_evt |-> (!r_en_n && r_wr_n && !r_oe_n && r_addr == HI));

  assert_l_rdqual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    l_clr_evt |-> (!l_en_n && l_wr_n && !l_oe_n && l_addr == LO));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_set_evt && r_clr_evt) |=> !r_irq_n);

endmodule

bind mbx_irq_intr mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .l_en_n   (l_en_n),
  .l_wr_n   (l_wr_n),
  .l_oe_n   (l_oe_n),
  .l_addr   (l_addr),
  .r_en_n   (r_en_n),
  .r_wr_n   (r_wr_n),
  .r_oe_n   (r_oe_n),
  .r_addr   (r_addr),
  .l_irq_n  (l_irq_n),
  .r_irq_n  (r_irq_n),
  .l_set_evt(l_set_evt),
  .l_clr_evt(l_clr_evt),
  .r_set_evt(r_set_evt),
  .r_clr_evt(r_clr_evt)
);

// File: tb/mbx_irq_intr_tb.sv
module mbx_irq_intr_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_TOP  = 12'hFFF;
  localparam logic [11:0] A_NEXT = 12'hFFE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        l_en_n, l_wr_n, l_oe_n;
  logic [11:0] l_addr;
  logic        r_en_n, r_wr_n, r_oe_n;
  logic [11:0] r_addr;
  logic        l_irq_n, r_irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq_intr u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b at %0t", req, got, exp, $time);
    end
  endtask

  // one cycle: active-high arguments (e = enabled, w = write, o = output on)
  task automatic step(input logic le, input logic lw, input logic lo,
                      input logic [11:0] la,
                      input logic re, input logic rw, input logic ro,
                      input logic [11:0] ra);
    l_en_n = ~le; l_wr_n = ~lw; l_oe_n = ~lo; l_addr = la;
    r_en_n = ~re; r_wr_n = ~rw; r_oe_n = ~ro; r_addr = ra;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 12'h000, 0, 0, 0, 12'h000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    l_en_n = 1'b1; l_wr_n = 1'b1; l_oe_n = 1'b1; l_addr = '0;
    r_en_n = 1'b1; r_wr_n = 1'b1; r_oe_n = 1'b1; r_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 left in reset", l_irq_n, 1'b1);
    check("R1 right in reset", r_irq_n, 1'b1);
    rst_n = 1'b1;
    idle();
    check("R1 left after reset", l_irq_n, 1'b1);
    check("R1 right after reset", r_irq_n, 1'b1);
  endtask

  task automatic t_left_to_right();
    step(1, 1, 0, A_TOP, 0, 0, 0, 12'h000);
    check("R2 right set", r_irq_n, 1'b0);
    check("R2 left untouched", l_irq_n, 1'b1);
    idle();
    check("R2 right holds", r_irq_n, 1'b0);
    step(0, 0, 0, 12'h000, 1, 0, 1, A_TOP);
    check("R3 right cleared", r_irq_n, 1'b1);
    idle();
  endtask

  task automatic t_right_to_left();
    step(0, 0, 0, 12'h000, 1, 1, 0, A_NEXT);
    check("R4 left set", l_irq_n, 1'b0);
    check("R4 right untouched", r_irq_n, 1'b1);
    idle();
    step(1, 0, 1, A_NEXT, 0, 0, 0, 12'h000);
    check("R5 left cleared", l_irq_n, 1'b1);
    idle();
  endtask

  task automatic t_own_addr();
    step(1, 1, 0, A_TOP, 1, 1, 0, A_NEXT);   // set both
    idle();
    step(1, 1, 0, A_NEXT, 1, 1, 0, A_TOP);   // own-clear writes
    check("R7 own write left", l_irq_n, 1'b0);
    check("R7 own write right", r_irq_n, 1'b0);
    idle();
    step(1, 0, 1, A_TOP, 1, 0, 1, A_NEXT);   // reading the other mailbox
    check("R7 wrong read left", l_irq_n, 1'b0);
    check("R7 wrong read right", r_irq_n, 1'b0);
    step(1, 0, 1, 12'h123, 1, 0, 1, 12'h7FF); // other addresses
    check("R7 other read left", l_irq_n, 1'b0);
    check("R7 other read right", r_irq_n, 1'b0);
    idle();
    step(1, 0, 1, A_NEXT, 1, 0, 1, A_TOP);   // proper clears
    check("R5 both clear left", l_irq_n, 1'b1);
    check("R3 both clear right", r_irq_n, 1'b1);
    step(1, 1, 0, 12'h123, 1, 1, 0, 12'h000);
    check("R7 other write left", l_irq_n, 1'b1);
    check("R7 other write right", r_irq_n, 1'b1);
    idle();
  endtask

  task automatic t_read_qual();
    step(1, 1, 0, A_TOP, 1, 1, 0, A_NEXT);
    idle();
    step(1, 0, 0, A_NEXT, 1, 0, 0, A_TOP);   // output enable off
    check("R8 no oe left", l_irq_n, 1'b0);
    check("R8 no oe right", r_irq_n, 1'b0);
    step(0, 0, 1, A_NEXT, 0, 0, 1, A_TOP);   // port disabled
    check("R8 disabled left", l_irq_n, 1'b0);
    check("R8 disabled right", r_irq_n, 1'b0);
    step(1, 0, 1, A_NEXT, 1, 0, 1, A_TOP);
    check("R8 real read left", l_irq_n, 1'b1);
    check("R8 real read right", r_irq_n, 1'b1);
    idle();
  endtask

  task automatic t_strobe();
    // enable first, write select last
    step(1, 0, 0, A_TOP, 0, 0, 0, 12'h000);
    check("R6 enable only", r_irq_n, 1'b1);
    step(1, 1, 0, A_TOP, 0, 0, 0, 12'h000);
    check("R6 write select last", r_irq_n, 1'b0);
    step(1, 1, 0, A_TOP, 1, 0, 1, A_TOP);    // held write, clear
    check("R6 held write cleared", r_irq_n, 1'b1);
    step(1, 1, 0, A_TOP, 0, 0, 0, 12'h000);
    check("R6 held write no reset", r_irq_n, 1'b1);
    idle();
    // write select first, enable last
    step(0, 1, 0, A_TOP, 0, 0, 0, 12'h000);
    check("R6 select only", r_irq_n, 1'b1);
    step(1, 1, 0, A_TOP, 0, 0, 0, 12'h000);
    check("R6 enable last", r_irq_n, 1'b0);
    step(0, 0, 0, 12'h000, 1, 0, 1, A_TOP);
    check("R3 clear again", r_irq_n, 1'b1);
    // strobe starts elsewhere, address slides onto the mailbox
    step(0, 0, 0, 12'h000, 1, 1, 0, 12'h010);
    step(0, 0, 0, 12'h000, 1, 1, 0, A_NEXT);
    check("R6 slide onto mailbox", l_irq_n, 1'b1);
    idle();
  endtask

  task automatic t_collide();
    step(1, 1, 0, A_TOP, 1, 0, 1, A_TOP);    // set and clear, flag idle
    check("R9 set wins from idle", r_irq_n, 1'b0);
    idle();
    step(1, 1, 0, A_TOP, 1, 0, 1, A_TOP);    // set and clear, flag active
    check("R9 set wins when active", r_irq_n, 1'b0);
    step(1, 0, 1, A_NEXT, 1, 1, 0, A_NEXT);
    check("R9 left set wins", l_irq_n, 1'b0);
    idle();
    step(1, 0, 1, A_NEXT, 1, 0, 1, A_TOP);
    check("R5 final clear left", l_irq_n, 1'b1);
    check("R3 final clear right", r_irq_n, 1'b1);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_left_to_right();
    t_right_to_left();
    t_own_addr();
    t_read_qual();
    t_strobe();
    t_collide();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule